// File: doc/BRIEF.md
# Watchdog and Low-Supply Reset Supervisor

This block produces a system reset from two independent causes. The first is a digital flag that reports a low supply; it takes the place of an analog voltage comparator, which is outside this block. The second is a watchdog timer. The watchdog expires if the host does not service it within the selected interval. The host services the watchdog by holding the serial chip-select line low for a minimum number of clock cycles and then releasing it. The reset is driven on two outputs, one active high and one active low.

A 2-bit selector picks the watchdog interval or turns the watchdog off. The selector comes from external nonvolatile storage and is expected to stay stable. All timing counts pulses of a one-cycle millisecond tick. Each time reset is asserted, it stays asserted until the full hold period has run with the supply good. The host cannot shorten the hold period by driving chip-select while reset is active.

All inputs are synchronous to `clk`. Both outputs are registered, so a result shows one clock after the edge that samples its cause. The bench uses shortened tick counts.

Top module: `wdt_reset_supervisor`

## Requirements
- R1: While `rstN` is low, `resetHigh` is 1 and `resetLowN` is 0, and ticks have no effect.
- R2: After power-on, reset is released on the clock edge that samples the HOLD_TICKS-th tick. It is still asserted after HOLD_TICKS-1 ticks.
- R3: With the watchdog enabled and no service, reset asserts on the edge that samples the N-th tick after release. N is WD_SHORT_TICKS for code `wdSel`=2'b10, WD_MID_TICKS for 2'b01 and WD_LONG_TICKS for 2'b00.
- R4: A watchdog reset is held for exactly HOLD_TICKS ticks. After that the watchdog restarts its count from zero.
- R5: Code `wdSel`=2'b11 disables the watchdog, so no number of ticks produces a reset.
- R6: A low pulse on `chipSelN` lasting at least CS_MIN_CYCLES clocks restarts the watchdog count on the clock where `chipSelN` returns high.
- R7: A low pulse on `chipSelN` shorter than CS_MIN_CYCLES clocks is ignored, and the watchdog count continues.
- R8: When `supplyLow` is 1, reset is asserted on the next clock edge and held for as long as the flag stays 1. Each clock with the flag at 1 restarts the hold count, so release comes HOLD_TICKS ticks after the flag clears.
- R9: Activity on `chipSelN` while reset is asserted does not shorten the hold period.
- R10: `resetLowN` is always the complement of `resetHigh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| msTick | input | 1 | One-cycle pulse each millisecond |
| supplyLow | input | 1 | Low-supply flag, active high |
| chipSelN | input | 1 | Serial chip-select, active low; a long enough low pulse services the watchdog |
| wdSel | input | 2 | Watchdog interval: 10 short, 01 mid, 00 long, 11 off |
| resetHigh | output | 1 | Reset output, active high |
| resetLowN | output | 1 | Reset output, active low |

## Verification
Every output change is due one clock after the edge that samples its cause: a tick, a supply flag, or `chipSelN` rising. The bench drives inputs on the falling edge, holds each tick for exactly one rising edge, and samples the outputs on the next falling edge. Each check therefore sees the state set by the edge that consumed the stimulus. Tick-count boundaries are checked on both sides: one tick before the expected edge and on the edge itself.

// File: rtl/wdt_sup_pkg.sv
package wdt_sup_pkg;
  typedef enum logic {ST_HOLD = 1'b0, ST_RUN = 1'b1} supState_t;

  typedef struct packed {
    logic holdClr;
    logic holdInc;
    logic wdClr;
    logic wdInc;
  } ctlStrobes_t;

  localparam logic [1:0] SEL_SHORT = 2'b10;
  localparam logic [1:0] SEL_MID   = 2'b01;
  localparam logic [1:0] SEL_LONG  = 2'b00;
  localparam logic [1:0] SEL_OFF   = 2'b11;
endpackage

// File: rtl/wdt_sup_datapath.sv
module wdt_sup_datapath
  import wdt_sup_pkg::*;
#(
  parameter int HOLD_TICKS     = 200,
  parameter int WD_SHORT_TICKS = 200,
  parameter int WD_MID_TICKS   = 600,
  parameter int WD_LONG_TICKS  = 1400,
  parameter int CS_MIN_CYCLES  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  input  logic        chipSelN,
  input  logic [1:0]  wdSel,
  output logic        holdLast,
  output logic        wdLast,
  output logic        wdEnable,
  output logic        kick
);
  localparam int WD_MAX1 = (WD_SHORT_TICKS > WD_MID_TICKS) ? WD_SHORT_TICKS : WD_MID_TICKS;
  localparam int WD_MAX  = (WD_MAX1 > WD_LONG_TICKS) ? WD_MAX1 : WD_LONG_TICKS;
  localparam int WD_W    = $clog2(WD_MAX + 1);
  localparam int HOLD_W  = $clog2(HOLD_TICKS + 1);
  localparam int CS_W    = $clog2(CS_MIN_CYCLES + 1);

  logic [HOLD_W-1:0] holdCnt;
  logic [WD_W-1:0]   wdCnt;
  logic [WD_W-1:0]   wdLimit;
  logic [CS_W-1:0]   csCnt;

  always_comb begin
    unique case (wdSel)
      SEL_SHORT: wdLimit = WD_W'(WD_SHORT_TICKS);
      SEL_MID:   wdLimit = WD_W'(WD_MID_TICKS);
      SEL_LONG:  wdLimit = WD_W'(WD_LONG_TICKS);
      default:   wdLimit = WD_W'(WD_SHORT_TICKS);
    endcase
  end

  assign wdEnable = (wdSel != SEL_OFF);
  assign wdLast   = wdEnable && (wdCnt >= wdLimit - WD_W'(1));
  assign holdLast = (holdCnt == HOLD_W'(HOLD_TICKS - 1));
  assign kick     = chipSelN && (csCnt == CS_W'(CS_MIN_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdCnt <= '0;
    else if (strobes.holdClr) holdCnt <= '0;
    else if (strobes.holdInc) holdCnt <= holdCnt + HOLD_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wdCnt <= '0;
    else if (strobes.wdClr) wdCnt <= '0;
    else if (strobes.wdInc) wdCnt <= wdCnt + WD_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 csCnt <= '0;
    else if (chipSelN)                         csCnt <= '0;
    else if (csCnt != CS_W'(CS_MIN_CYCLES))    csCnt <= csCnt + CS_W'(1);
  end

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt < HOLD_W'(HOLD_TICKS)); // R2
  AST_WD_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !wdEnable |=> wdCnt == '0); // R5
  AST_CS_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    csCnt <= CS_W'(CS_MIN_CYCLES)); // R7
endmodule

// File: rtl/wdt_sup_control.sv
module wdt_sup_control
  import wdt_sup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        msTick,
  input  logic        supplyLow,
  input  logic        holdLast,
  input  logic        wdLast,
  input  logic        wdEnable,
  input  logic        kick,
  output ctlStrobes_t strobes,
  output logic        resetHighQ,
  output logic        resetLowQ
);
  supState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '{holdClr: 1'b0, holdInc: 1'b0, wdClr: 1'b1, wdInc: 1'b0};
    unique case (state)
      ST_HOLD: begin
        if (supplyLow) begin
          strobes.holdClr = 1'b1;
        end else if (msTick) begin
          if (holdLast) begin
            stateNext       = ST_RUN;
            strobes.holdClr = 1'b1;
          end else begin
            strobes.holdInc = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (supplyLow) begin
          stateNext       = ST_HOLD;
          strobes.holdClr = 1'b1;
        end else if (kick) begin
          strobes.wdClr = 1'b1;
        end else if (wdEnable) begin
          strobes.wdClr = 1'b0;
          if (msTick) begin
            if (wdLast) begin
              stateNext       = ST_HOLD;
              strobes.holdClr = 1'b1;
              strobes.wdClr   = 1'b1;
            end else begin
              strobes.wdInc = 1'b1;
            end
          end
        end
      end
      default: stateNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_HOLD;
      resetHighQ <= 1'b1;
      resetLowQ  <= 1'b0;
    end else begin
      state      <= stateNext;
      resetHighQ <= (stateNext == ST_HOLD);
      resetLowQ  <= (stateNext == ST_RUN);
    end
  end

  AST_SUPPLY_FORCES_RESET: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> resetHighQ); // R8
  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rstN)
    resetLowQ != resetHighQ); // R10
  AST_RELEASE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetHighQ) |-> ($past(msTick) && !$past(supplyLow))); // R2
  AST_ASSERT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetHighQ) |-> ($past(supplyLow) || $past(msTick))); // R3
endmodule

// File: rtl/wdt_reset_supervisor.sv
module wdt_reset_supervisor
  import wdt_sup_pkg::*;
#(
  parameter int HOLD_TICKS     = 200,
  parameter int WD_SHORT_TICKS = 200,
  parameter int WD_MID_TICKS   = 600,
  parameter int WD_LONG_TICKS  = 1400,
  parameter int CS_MIN_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       supplyLow,
  input  logic       chipSelN,
  input  logic [1:0] wdSel,
  output logic       resetHigh,
  output logic       resetLowN
);
  ctlStrobes_t strobes;
  logic holdLast, wdLast, wdEnable, kick;

  wdt_sup_datapath #(
    .HOLD_TICKS    (HOLD_TICKS),
    .WD_SHORT_TICKS(WD_SHORT_TICKS),
    .WD_MID_TICKS  (WD_MID_TICKS),
    .WD_LONG_TICKS (WD_LONG_TICKS),
    .CS_MIN_CYCLES (CS_MIN_CYCLES)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .chipSelN(chipSelN),
    .wdSel   (wdSel),
    .holdLast(holdLast),
    .wdLast  (wdLast),
    .wdEnable(wdEnable),
    .kick    (kick)
  );

  wdt_sup_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .msTick    (msTick),
    .supplyLow (supplyLow),
    .holdLast  (holdLast),
    .wdLast    (wdLast),
    .wdEnable  (wdEnable),
    .kick      (kick),
    .strobes   (strobes),
    .resetHighQ(resetHigh),
    .resetLowQ (resetLowN)
  );
endmodule

// File: tb/test_wdt_reset_supervisor.sv
module test_wdt_reset_supervisor;
  localparam int HOLD  = 5;
  localparam int TSH   = 8;
  localparam int TMID  = 16;
  localparam int TLONG = 32;
  localparam int CSMIN = 3;

  logic clk = 1'b0;
  logic rstN, msTick, supplyLow, chipSelN;
  logic [1:0] wdSel;
  logic resetHigh, resetLowN;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  wdt_reset_supervisor #(
    .HOLD_TICKS(HOLD), .WD_SHORT_TICKS(TSH), .WD_MID_TICKS(TMID),
    .WD_LONG_TICKS(TLONG), .CS_MIN_CYCLES(CSMIN)
  ) i_wdt_reset_supervisor (
    .clk(clk), .rstN(rstN), .msTick(msTick), .supplyLow(supplyLow),
    .chipSelN(chipSelN), .wdSel(wdSel), .resetHigh(resetHigh), .resetLowN(resetLowN)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic checkRst(input logic exp, input string req);
    total++;
    if (resetHigh !== exp || resetLowN !== ~exp) begin
      bad++;
      $display("FAIL %s: actual resetHigh=%b resetLowN=%b expected resetHigh=%b resetLowN=%b",
               req, resetHigh, resetLowN, exp, ~exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) msTick = 1'b1;
      @(negedge clk) msTick = 1'b0;
    end
  endtask

  task automatic csPulse(input int n);
    @(negedge clk) chipSelN = 1'b0;
    repeat (n) @(negedge clk);
    chipSelN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tPowerOn();
    ticks(3);
    checkRst(1'b1, "R1");
    @(negedge clk) rstN = 1'b1;
    ticks(HOLD - 1);
    checkRst(1'b1, "R2");
    ticks(1);
    checkRst(1'b0, "R2");
    total++;
    if (resetLowN !== ~resetHigh) begin
      bad++;
      $display("FAIL R10: actual resetLowN=%b expected %b", resetLowN, ~resetHigh);
    end
  endtask

  task automatic tTimeout(input logic [1:0] sel, input int lim);
    wdSel = sel;
    ticks(lim - 1);
    checkRst(1'b0, "R3");
    ticks(1);
    checkRst(1'b1, "R3");
    ticks(HOLD - 1);
    checkRst(1'b1, "R4");
    ticks(1);
    checkRst(1'b0, "R4");
  endtask

  task automatic tDisabled();
    wdSel = 2'b11;
    ticks(3 * TLONG);
    checkRst(1'b0, "R5");
    wdSel = 2'b10;
  endtask

  task automatic tKick();
    ticks(TSH - 1);
    csPulse(CSMIN);
    ticks(TSH - 1);
    checkRst(1'b0, "R6");
    ticks(1);
    checkRst(1'b1, "R6");
    ticks(HOLD);
    checkRst(1'b0, "R4");
  endtask

  task automatic tShortPulseAndHold();
    ticks(TSH - 2);
    csPulse(CSMIN - 1);
    ticks(1);
    checkRst(1'b0, "R7");
    ticks(1);
    checkRst(1'b1, "R7");
    for (int i = 0; i < HOLD - 1; i++) begin
      csPulse(CSMIN + i);
      ticks(1);
    end
    csPulse(CSMIN + 2);
    checkRst(1'b1, "R9");
    ticks(1);
    checkRst(1'b0, "R9");
  endtask

  task automatic tSupply();
    @(negedge clk) supplyLow = 1'b1;
    @(negedge clk);
    checkRst(1'b1, "R8");
    ticks(2 * HOLD);
    checkRst(1'b1, "R8");
    supplyLow = 1'b0;
    ticks(HOLD - 2);
    supplyLow = 1'b1;
    @(negedge clk) supplyLow = 1'b0;
    ticks(HOLD - 1);
    checkRst(1'b1, "R8");
    ticks(1);
    checkRst(1'b0, "R8");
    ticks(TSH - 1);
    checkRst(1'b0, "R4");
  endtask

  initial begin
    rstN = 1'b0; msTick = 1'b0; supplyLow = 1'b0; chipSelN = 1'b1; wdSel = 2'b10;
    tPowerOn();
    tTimeout(2'b10, TSH);
    tTimeout(2'b01, TMID);
    tTimeout(2'b00, TLONG);
    wdSel = 2'b10;
    tDisabled();
    tKick();
    tShortPulseAndHold();
    tSupply();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule